// File: doc/BRIEF.md
# Message Buffer Access Window

This block gives a host processor byte-wide access to the message stores of several HDLC controllers through one data address. Each controller owns a 96-byte transmit store and a 96-byte receive store. A select register picks the controller that the host reaches. The transmit and receive stores are separate, so bytes the host writes through the data address go only to the transmit store, and reads through the same address come only from the receive store. The host therefore never sees the bytes it wrote.

The block keeps an independent write pointer and read pointer. Each access through the data address moves its pointer to the next byte, so the host can stream a whole message without changing the address. Reads return real data only after the selected controller has signalled the end of a received message. That event raises an interrupt, which stays raised until software clears it. A send request hands the transmit store to the controller, together with the number of bytes that were written.

The host bus has four registers, selected by `host_addr`: 0 is the data window, 1 is the controller select, 2 is control/status, and 3 is reserved and reads 0. The framing, flag, CRC and line logic belong to the controllers and are not part of this block.

Top module: `msg_window`

## Requirements
- R1: After reset, `host_rdata`, `irq`, `tx_send` and `tx_count` are 0, the select register reads 0, and both pointers start at byte 0.
- R2: A host write to address 0 stores `host_wdata` at the write pointer in the selected controller's transmit store, then advances the write pointer. The byte can be seen on that controller's `tx_rd_addr`/`tx_rd_data` port. The other controllers' stores do not change.
- R3: A write to address 1 with a value below NUM_CTRL selects that controller and returns both pointers to byte 0. A larger value is ignored. A read of address 1 returns the current selection.
- R4: A host read of address 0, while the selected controller has an end-of-transfer pending, returns the receive byte at the read pointer on `host_rdata` one cycle later, then advances the read pointer. Any register read updates `host_rdata` one cycle after the strobe, and `host_rdata` holds its value otherwise.
- R5: A read of address 0 while no end-of-transfer is pending for the selected controller returns 0 and leaves the read pointer unchanged.
- R6: Each pointer stops at DEPTH (96). A write at that point is ignored. A read at that point, with an end-of-transfer pending, returns 0.
- R7: Any access ignored under R6 sets a sticky overflow flag, read as bit 1 of address 2. Writing 1 to bit 2 of address 2 clears it.
- R8: Writing 1 to bit 0 of address 2 gives a one-cycle pulse, on the next cycle, on the selected controller's `tx_send` bit. At the same time `tx_count` is loaded with the number of bytes written, and the write pointer returns to 0. `tx_count` holds its value between sends.
- R9: A pulse on `rx_eot[i]` marks controller i as pending. `irq` is the OR of all pending marks. Bit 0 of address 2 shows the mark of the selected controller. A mark stays set until the host writes 1 to bit 1 of address 2 while that controller is selected. If a new end-of-transfer arrives in the same cycle as the clear, the mark stays set.
- R10: An end-of-transfer pulse from the selected controller returns both pointers to byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Register select: 0 data, 1 select, 2 control/status, 3 reserved |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Registered host read data |
| irq | output | 1 | End-of-transfer interrupt |
| tx_send | output | NUM_CTRL | One-cycle send request per controller |
| tx_count | output | PW | Byte count that goes with a send request |
| tx_rd_addr | input | NUM_CTRL*PW | Per-controller transmit store read address |
| tx_rd_data | output | NUM_CTRL*DW | Per-controller transmit store read data |
| rx_we | input | NUM_CTRL | Per-controller receive store write enable |
| rx_waddr | input | NUM_CTRL*PW | Per-controller receive store write address |
| rx_wdata | input | NUM_CTRL*DW | Per-controller receive store write data |
| rx_eot | input | NUM_CTRL | Per-controller end-of-transfer pulse |

## Verification
The assertions check, on every cycle, the rules that hold for each state:
- the pointers never pass DEPTH;
- a read advances the read pointer by one, and an unready read returns zero;
- a select write clears both pointers;
- at most one send pulse is active, and it carries the pre-send write count;
- the interrupt and overflow flag stay set until their clear bits are written.

Only the bench scenarios can show whole-message content: the transmit bytes seen on a controller's port, receive bytes returned in order across a full 96-byte message, and the other controller's store left untouched. They also show the sequences that involve both controllers: a pending mark on an unselected controller driving `irq`, and an end-of-transfer restarting the read stream partway through a message.

// File: rtl/msg_window_pkg.sv
package msg_window_pkg;

   localparam int REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      REG_DATA = 2'd0,
      REG_SEL  = 2'd1,
      REG_CTRL = 2'd2,
      REG_RSVD = 2'd3
   } win_reg_e;

   // control write bits
   localparam int CTL_SEND    = 0;
   localparam int CTL_EOT_CLR = 1;
   localparam int CTL_OVF_CLR = 2;

   // status read bits
   localparam int STS_EOT = 0;
   localparam int STS_OVF = 1;

endpackage

// File: rtl/msg_ptr.sv
module msg_ptr #(
   parameter int DEPTH = 96,
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          adv,
   output logic [PW-1:0] ptr,
   output logic          at_end
);

   localparam logic [PW-1:0] LAST = PW'(DEPTH);

   assign at_end = (ptr == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (clr) begin
         ptr <= '0;
      end else if (adv && !at_end) begin
         ptr <= ptr + 1'b1;
      end
   end

endmodule

// File: rtl/msg_store.sv
module msg_store #(
   parameter int DEPTH = 96,
   parameter int DW    = 8,
   parameter int PW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   // host side of the transmit store
   input  logic          tx_we,
   input  logic [PW-1:0] tx_waddr,
   input  logic [DW-1:0] tx_wdata,
   // controller side of the transmit store
   input  logic [PW-1:0] tx_raddr,
   output logic [DW-1:0] tx_rdata,
   // controller side of the receive store
   input  logic          rx_we,
   input  logic [PW-1:0] rx_waddr,
   input  logic [DW-1:0] rx_wdata,
   // host side of the receive store
   input  logic [PW-1:0] rx_raddr,
   output logic [DW-1:0] rx_rdata
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PW-1:0] LIM = PW'(DEPTH);

   logic [DW-1:0] tx_mem [DEPTH];
   logic [DW-1:0] rx_mem [DEPTH];

   always_ff @(posedge clk) begin
      if (tx_we && (tx_waddr < LIM)) begin
         tx_mem[tx_waddr[AW-1:0]] <= tx_wdata;
      end
      if (rx_we && (rx_waddr < LIM)) begin
         rx_mem[rx_waddr[AW-1:0]] <= rx_wdata;
      end
   end

   assign tx_rdata = (tx_raddr < LIM) ? tx_mem[tx_raddr[AW-1:0]] : '0;
   assign rx_rdata = (rx_raddr < LIM) ? rx_mem[rx_raddr[AW-1:0]] : '0;

endmodule

// File: rtl/msg_window.sv
module msg_window
   import msg_window_pkg::*;
#(
   parameter int NUM_CTRL = 2,
   parameter int DEPTH    = 96,
   parameter int DW       = 8,
   localparam int PW      = $clog2(DEPTH + 1),
   localparam int SW      = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   host_sel,
   input  logic                   host_we,
   input  logic [REG_AW-1:0]      host_addr,
   input  logic [DW-1:0]          host_wdata,
   output logic [DW-1:0]          host_rdata,
   output logic                   irq,
   output logic [NUM_CTRL-1:0]    tx_send,
   output logic [PW-1:0]          tx_count,
   input  logic [NUM_CTRL*PW-1:0] tx_rd_addr,
   output logic [NUM_CTRL*DW-1:0] tx_rd_data,
   input  logic [NUM_CTRL-1:0]    rx_we,
   input  logic [NUM_CTRL*PW-1:0] rx_waddr,
   input  logic [NUM_CTRL*DW-1:0] rx_wdata,
   input  logic [NUM_CTRL-1:0]    rx_eot
);

   // elaboration-time parameter checks
   if (NUM_CTRL < 1 || NUM_CTRL > 16) begin : g_bad_nctrl
      $error("msg_window: NUM_CTRL must be 1..16");
   end
   if (DEPTH < 2 || DEPTH > 1024) begin : g_bad_depth
      $error("msg_window: DEPTH must be 2..1024");
   end
   if (DW < 4 || DW < SW) begin : g_bad_dw
      $error("msg_window: DW too narrow for status and select");
   end

   // ---------------- host decode ----------------
   logic host_wr, host_rd;
   logic win_wr, win_rd, sel_wr, ctl_wr;
   logic [SW-1:0] sel_q;
   logic [NUM_CTRL-1:0] eot_pend_q;
   logic ovf_q;
   logic eot_cur, eot_here;
   logic wr_end, rd_end;
   logic wr_ok, rd_ok, wr_over, rd_over;
   logic send_req;
   logic [PW-1:0] wr_ptr, rd_ptr;

   assign host_wr = host_sel && host_we;
   assign host_rd = host_sel && !host_we;
   assign win_wr  = host_wr && (host_addr == REG_DATA);
   assign win_rd  = host_rd && (host_addr == REG_DATA);
   assign ctl_wr  = host_wr && (host_addr == REG_CTRL);
   assign sel_wr  = host_wr && (host_addr == REG_SEL) &&
                    ({{(32-DW){1'b0}}, host_wdata} < 32'(NUM_CTRL));

   assign eot_cur  = eot_pend_q[sel_q];
   assign eot_here = rx_eot[sel_q];

   assign wr_ok   = win_wr && !wr_end;
   assign wr_over = win_wr && wr_end;
   assign rd_ok   = win_rd && eot_cur && !rd_end;
   assign rd_over = win_rd && eot_cur && rd_end;
   assign send_req = ctl_wr && host_wdata[CTL_SEND];

   // ---------------- pointers ----------------
   msg_ptr #(.DEPTH(DEPTH), .PW(PW)) u_wr_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sel_wr || eot_here || send_req),
      .adv    (wr_ok),
      .ptr    (wr_ptr),
      .at_end (wr_end)
   );

   msg_ptr #(.DEPTH(DEPTH), .PW(PW)) u_rd_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sel_wr || eot_here),
      .adv    (rd_ok),
      .ptr    (rd_ptr),
      .at_end (rd_end)
   );

   // ---------------- per-controller stores ----------------
   logic [DW-1:0] rx_rd_bus [NUM_CTRL];

   for (genvar gi = 0; gi < NUM_CTRL; gi++) begin : g_ctrl
      logic hit;
      assign hit = (sel_q == SW'(gi));

      msg_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
         .clk      (clk),
         .tx_we    (wr_ok && hit),
         .tx_waddr (wr_ptr),
         .tx_wdata (host_wdata),
         .tx_raddr (tx_rd_addr[gi*PW +: PW]),
         .tx_rdata (tx_rd_data[gi*DW +: DW]),
         .rx_we    (rx_we[gi]),
         .rx_waddr (rx_waddr[gi*PW +: PW]),
         .rx_wdata (rx_wdata[gi*DW +: DW]),
         .rx_raddr (rd_ptr),
         .rx_rdata (rx_rd_bus[gi])
      );

      // pending end-of-transfer mark; a new event beats a clear
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            eot_pend_q[gi] <= 1'b0;
         end else if (rx_eot[gi]) begin
            eot_pend_q[gi] <= 1'b1;
         end else if (ctl_wr && host_wdata[CTL_EOT_CLR] && hit) begin
            eot_pend_q[gi] <= 1'b0;
         end
      end
   end

   assign irq = |eot_pend_q;

   // ---------------- select, overflow, send ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (sel_wr) begin
         sel_q <= host_wdata[SW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovf_q <= 1'b0;
      end else if (wr_over || rd_over) begin
         ovf_q <= 1'b1;
      end else if (ctl_wr && host_wdata[CTL_OVF_CLR]) begin
         ovf_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_send  <= '0;
         tx_count <= '0;
      end else begin
         tx_send <= '0;
         if (send_req) begin
            tx_send[sel_q] <= 1'b1;
            tx_count       <= wr_ptr;
         end
      end
   end

   // ---------------- read data ----------------
   logic [DW-1:0] rd_next;

   always_comb begin
      rd_next = '0;
      case (host_addr)
         REG_DATA: rd_next = rd_ok ? rx_rd_bus[sel_q] : '0;
         REG_SEL:  rd_next = DW'(sel_q);
         REG_CTRL: begin
            rd_next[STS_EOT] = eot_cur;
            rd_next[STS_OVF] = ovf_q;
         end
         default:  rd_next = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd) begin
         host_rdata <= rd_next;
      end
   end

endmodule

// File: rtl/msg_window_chk.sv
module msg_window_chk
   import msg_window_pkg::*;
#(
   parameter int NUM_CTRL = 2,
   parameter int DEPTH    = 96,
   parameter int DW       = 8,
   localparam int PW      = $clog2(DEPTH + 1),
   localparam int SW      = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                host_sel,
   input logic                host_we,
   input logic [REG_AW-1:0]   host_addr,
   input logic [DW-1:0]       host_wdata,
   input logic [DW-1:0]       host_rdata,
   input logic                irq,
   input logic [NUM_CTRL-1:0] tx_send,
   input logic [PW-1:0]       tx_count,
   input logic [NUM_CTRL-1:0] rx_eot,
   input logic [PW-1:0]       wr_ptr,
   input logic [PW-1:0]       rd_ptr,
   input logic [SW-1:0]       sel_q,
   input logic [NUM_CTRL-1:0] eot_pend_q,
   input logic                ovf_q
);

   logic rd_win, sel_ok_wr, clr_eot_wr, clr_ovf_wr;
   assign rd_win     = host_sel && !host_we && (host_addr == REG_DATA);
   assign sel_ok_wr  = host_sel && host_we && (host_addr == REG_SEL) &&
                       ({{(32-DW){1'b0}}, host_wdata} < 32'(NUM_CTRL));
   assign clr_eot_wr = host_sel && host_we && (host_addr == REG_CTRL) && host_wdata[CTL_EOT_CLR];
   assign clr_ovf_wr = host_sel && host_we && (host_addr == REG_CTRL) && host_wdata[CTL_OVF_CLR];

   // R6: pointers never pass the end of the store
   a_r6_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ptr <= PW'(DEPTH)) && (rd_ptr <= PW'(DEPTH)));

   // R4: a ready read advances the read pointer by one
   a_r4_rd_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && eot_pend_q[sel_q] && (rd_ptr < PW'(DEPTH)) && !rx_eot[sel_q])
      |=> (rd_ptr == $past(rd_ptr) + 1'b1));

   // R5: an unready read returns zero
   a_r5_unready_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_win && !eot_pend_q[sel_q]) |=> (host_rdata == '0));

   // R3: a valid select write restarts both pointers
   a_r3_sel_reset: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ok_wr |=> ((wr_ptr == '0) && (rd_ptr == '0)));

   // R7: overflow flag is sticky until cleared
   a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr_ovf_wr) |=> ovf_q);

   // R8: one send pulse at a time, carrying the pre-send count
   a_r8_send_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tx_send));
   a_r8_send_count: assert property (@(posedge clk) disable iff (!rst_n)
      (|tx_send) |-> (tx_count == $past(wr_ptr)));

   // R9: interrupt raised by any event and held until a clear write
   a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (|rx_eot) |=> irq);
   a_r9_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !clr_eot_wr) |=> irq);

endmodule

bind msg_window msg_window_chk #(
   .NUM_CTRL (NUM_CTRL),
   .DEPTH    (DEPTH),
   .DW       (DW)
) u_chk (.*);

// File: tb/msg_window_bench.sv
module msg_window_bench;

   localparam int N  = 2;
   localparam int D  = 96;
   localparam int DW = 8;
   localparam int PW = $clog2(D + 1);

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            host_sel = 1'b0;
   logic            host_we = 1'b0;
   logic [1:0]      host_addr = '0;
   logic [DW-1:0]   host_wdata = '0;
   logic [DW-1:0]   host_rdata;
   logic            irq;
   logic [N-1:0]    tx_send;
   logic [PW-1:0]   tx_count;
   logic [N*PW-1:0] tx_rd_addr = '0;
   logic [N*DW-1:0] tx_rd_data;
   logic [N-1:0]    rx_we = '0;
   logic [N*PW-1:0] rx_waddr = '0;
   logic [N*DW-1:0] rx_wdata = '0;
   logic [N-1:0]    rx_eot = '0;

   always #2 clk = ~clk;   // 250 MHz

   msg_window #(.NUM_CTRL(N), .DEPTH(D), .DW(DW)) u_msg_window (.*);

   int checks = 0;
   int fails  = 0;

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   // ---------------- behavioural reference model ----------------
   int m_tx [N][D];
   int m_rx [N][D];
   int m_eot [N];
   int m_sel, m_wp, m_rp, m_ovf, m_rdata, m_send, m_cnt;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_sel = 0; m_wp = 0; m_rp = 0; m_ovf = 0;
         m_rdata = 0; m_send = 0; m_cnt = 0;
         foreach (m_eot[i]) m_eot[i] = 0;
      end else begin
         int ready, adv_w, adv_r, over, restart, sendq, clr_e, new_sel;
         ready = m_eot[m_sel];
         adv_w = 0; adv_r = 0; over = 0; restart = 0; sendq = 0; clr_e = 0;
         new_sel = m_sel;
         if (host_sel && !host_we) begin
            if (host_addr == 0) begin
               if (ready != 0 && m_rp < D) begin
                  m_rdata = m_rx[m_sel][m_rp]; adv_r = 1;
               end else begin
                  m_rdata = 0;
                  if (ready != 0) over = 1;
               end
            end else if (host_addr == 1) m_rdata = m_sel;
            else if (host_addr == 2) m_rdata = m_ovf * 2 + ready;
            else m_rdata = 0;
         end
         if (host_sel && host_we) begin
            if (host_addr == 0) begin
               if (m_wp < D) begin
                  m_tx[m_sel][m_wp] = int'(host_wdata); adv_w = 1;
               end else over = 1;
            end else if (host_addr == 1) begin
               if (int'(host_wdata) < N) begin
                  restart = 1; new_sel = int'(host_wdata);
               end
            end else if (host_addr == 2) begin
               sendq = int'(host_wdata[0]);
               clr_e = int'(host_wdata[1]);
               if (host_wdata[2] && over == 0) m_ovf = 0;
            end
         end
         if (over != 0) m_ovf = 1;
         for (int i = 0; i < N; i++)
            if (rx_we[i] && int'(rx_waddr[i*PW +: PW]) < D)
               m_rx[i][int'(rx_waddr[i*PW +: PW])] = int'(rx_wdata[i*DW +: DW]);
         m_send = (sendq != 0) ? (1 << m_sel) : 0;
         if (sendq != 0) m_cnt = m_wp;
         if (restart != 0 || rx_eot[m_sel] || sendq != 0) m_wp = 0;
         else m_wp = m_wp + adv_w;
         if (restart != 0 || rx_eot[m_sel]) m_rp = 0;
         else m_rp = m_rp + adv_r;
         for (int i = 0; i < N; i++) begin
            if (rx_eot[i]) m_eot[i] = 1;
            else if (clr_e != 0 && i == m_sel) m_eot[i] = 0;
         end
         m_sel = new_sel;
      end
   end

   // clock-by-clock comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         int any;
         any = 0;
         foreach (m_eot[i]) any = any | m_eot[i];
         chk("R4 host_rdata vs model", int'(host_rdata), m_rdata);
         chk("R9 irq vs model", int'(irq), any);
         chk("R8 tx_send vs model", int'(tx_send), m_send);
         chk("R8 tx_count vs model", int'(tx_count), m_cnt);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic bus_wr(int a, int d);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b1; host_addr = 2'(a); host_wdata = 8'(d);
      @(negedge clk);
      host_sel = 1'b0; host_we = 1'b0;
   endtask

   task automatic bus_rd(int a, output int v);
      @(negedge clk);
      host_sel = 1'b1; host_we = 1'b0; host_addr = 2'(a);
      @(negedge clk);
      host_sel = 1'b0;
      v = int'(host_rdata);
   endtask

   task automatic rx_push(int c, int a, int d);
      @(negedge clk);
      rx_we[c] = 1'b1;
      rx_waddr[c*PW +: PW] = PW'(a);
      rx_wdata[c*DW +: DW] = 8'(d);
      @(negedge clk);
      rx_we[c] = 1'b0;
   endtask

   task automatic rx_fire(int c);
      @(negedge clk);
      rx_eot[c] = 1'b1;
      @(negedge clk);
      rx_eot[c] = 1'b0;
   endtask

   task automatic tx_peek(int c, int a, output int v);
      tx_rd_addr[c*PW +: PW] = PW'(a);
      #1;
      v = int'(tx_rd_data[c*DW +: DW]);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      summary();
      $finish;
   end

   // ---------------- scenarios ----------------
   initial begin
      int v;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 rdata after reset", int'(host_rdata), 0);
      chk("R1 irq after reset", int'(irq), 0);
      chk("R1 tx_send after reset", int'(tx_send), 0);
      rst_n = 1'b1;
      bus_rd(1, v); chk("R1 select reads 0", v, 0);

      // R2: fill controller 0 transmit store
      for (int k = 0; k < 5; k++) bus_wr(0, 8'h10 + k);
      for (int k = 0; k < 5; k++) begin
         tx_peek(0, k, v); chk("R2 ctrl0 tx byte", v, 8'h10 + k);
      end
      // R8: send request
      bus_wr(2, 1);
      chk("R8 send pulse ctrl0", int'(tx_send), 1);
      chk("R8 count five", int'(tx_count), 5);
      @(negedge clk);
      chk("R8 pulse is one cycle", int'(tx_send), 0);

      // R3: select controller 1, ignored out-of-range select
      bus_wr(1, 1);
      bus_rd(1, v); chk("R3 select reads 1", v, 1);
      bus_wr(1, 5);
      bus_rd(1, v); chk("R3 bad select ignored", v, 1);
      for (int k = 0; k < 3; k++) bus_wr(0, 8'hA0 + k);
      for (int k = 0; k < 3; k++) begin
         tx_peek(1, k, v); chk("R2 ctrl1 tx byte", v, 8'hA0 + k);
         tx_peek(0, k, v); chk("R2 ctrl0 untouched", v, 8'h10 + k);
      end

      // R5: read before end-of-transfer
      bus_rd(0, v); chk("R5 unready read zero", v, 0);

      // R4 / R9: receive on controller 1
      for (int k = 0; k < 4; k++) rx_push(1, k, 8'h50 + k);
      rx_fire(1);
      chk("R9 irq raised", int'(irq), 1);
      bus_rd(2, v); chk("R9 status pending", v, 1);
      bus_rd(0, v); chk("R4 rx byte0", v, 8'h50);
      bus_rd(0, v); chk("R4 rx byte1", v, 8'h51);
      // R10: new event restarts the read stream
      rx_fire(1);
      bus_rd(0, v); chk("R10 restart byte0", v, 8'h50);
      bus_rd(0, v); chk("R10 then byte1", v, 8'h51);
      bus_wr(2, 2);
      chk("R9 irq cleared", int'(irq), 0);
      bus_rd(0, v); chk("R5 read after clear zero", v, 0);

      // R9: unselected controller still drives irq
      rx_fire(0);
      chk("R9 irq from ctrl0", int'(irq), 1);
      bus_rd(2, v); chk("R9 status shows selected only", v, 0);
      bus_wr(1, 0);
      bus_rd(2, v); chk("R9 status ctrl0 pending", v, 1);
      bus_wr(2, 2);
      chk("R9 irq cleared ctrl0", int'(irq), 0);

      // R6 / R7: fill all 96 bytes, then one more
      for (int k = 0; k < D; k++) bus_wr(0, (k * 3 + 1) & 255);
      bus_rd(2, v); chk("R7 no overflow yet", v, 0);
      bus_wr(0, 8'hEE);
      bus_rd(2, v); chk("R7 overflow set on write", v, 2);
      tx_peek(0, D - 1, v); chk("R6 last tx byte kept", v, ((D - 1) * 3 + 1) & 255);
      bus_wr(2, 1);
      chk("R8 count full store", int'(tx_count), D);
      bus_wr(2, 4);
      bus_rd(2, v); chk("R7 overflow cleared", v, 0);

      // R4 / R6: full receive message then one extra read
      for (int k = 0; k < D; k++) rx_push(0, k, (k * 7 + 2) & 255);
      rx_fire(0);
      for (int k = 0; k < D; k++) begin
         bus_rd(0, v); chk("R4 full rx byte", v, (k * 7 + 2) & 255);
      end
      bus_rd(0, v); chk("R6 read beyond end zero", v, 0);
      bus_rd(2, v); chk("R7 overflow set on read", v, 3);
      bus_rd(3, v); chk("R4 reserved reads zero", v, 0);

      repeat (2) @(negedge clk);
      summary();
      $finish;
   end

endmodule